// File: doc/BRIEF.md
# Sleep-Time Interrupt Capture and Replay Controller

This block stands between a group of external interrupt lines and a parent interrupt controller. The parent may lose power during sleep. Each line is synchronised and checked against its own trigger type. Every qualifying event is latched into a per-line status bit, and this recording continues whether or not the block is enabled. When software writes the replay command, each unmasked line that holds a recorded event sends a fresh one-cycle pulse toward the parent, and the recorded bit is then cleared.

Software reaches the block through a word-addressed 32-bit register port. Per-line configuration is held in mask, sensitivity and polarity vectors. Each vector has a write-one-to-set bank and a write-one-to-clear bank. Recorded events are cleared through a write-one-to-clear acknowledge bank. One control word holds the enable bit and the edge-only bit, and a write to its self-clearing replay bit starts a replay. While the block is disabled, each output follows its synchronised input. While the block is enabled, only replay pulses reach the outputs.

Top module: `irq_hold_replay`

## Requirements
- R1: After reset, line_out is all zero, the status, sensitivity, polarity and control registers read 0, and every mask bit reads 1.
- R2: Bank byte offsets are: status 0x000, acknowledge 0x040, mask-set 0x0C0, mask-clear 0x100, sensitivity-set 0x180, sensitivity-clear 0x1C0, polarity-set 0x240, polarity-clear 0x280, control 0x300. Line n is held in the word at bank offset + (n/32)*4, at bit n mod 32. A read of a set or clear address returns the current vector. reg_rdata is valid on the cycle after the read strobe is sampled.
- R3: In the mask, sensitivity and polarity banks, a 1 written to a set address sets the matching bit and a 1 written to a clear address clears it. Bits written as 0 leave the stored bit unchanged.
- R4: A line with sensitivity 0 is edge-triggered. With polarity 1 it records a rising edge of its synchronised input, and with polarity 0 it records a falling edge. Recording takes place even when the enable bit is 0.
- R5: A line with sensitivity 1 is level-triggered. It records an event on every cycle in which its synchronised input equals its polarity bit, unless the edge-only bit (control bit 1) is 1. In that case the line records nothing.
- R6: Writing 1 to a bit of the acknowledge bank clears the matching status bit, and 0 bits have no effect. If a new event occurs in the same cycle as the clear, the event is kept.
- R7: Writing 1 to control bit 2 starts a replay. In the second cycle after the write edge, line_out carries a one-cycle pulse on every line whose status bit is 1 and whose mask bit is 0. Those status bits are cleared. Masked lines keep their status bits.
- R8: Control bits 0 (enable) and 1 (edge-only) read back as written. Bit 2 always reads 0.
- R9: With enable at 0, each line_out bit follows its input through three register stages. With enable at 1, line_out is 0 except for replay pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| line_in | input | NUM_LINES | Asynchronous interrupt inputs |
| line_out | output | NUM_LINES | Registered outputs toward the parent controller |

## Verification
The bench builds the block with the default of 64 lines, which gives every bank two words. The second word at +4 is therefore decoded, and lines 32 to 63 can be checked across the word boundary. Line 33 is configured for falling edges and line 63 stays masked, so one replay shows a line that pulses and a masked line that keeps its status. Lines 0 and 5 cover rising-edge recording and level recording, both with and without the edge-only bit.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int WORD_BITS = 32;
  localparam int ADDR_W    = 10;
  localparam int BANK_LSB  = 6;                 // each bank spans 64 bytes
  localparam int WSEL_W    = BANK_LSB - 2;      // word index inside a bank
  localparam int BANK_W    = ADDR_W - BANK_LSB;

  typedef enum logic [BANK_W-1:0] {
    BK_STATUS = 4'd0,
    BK_ACK    = 4'd1,
    BK_MSET   = 4'd3,
    BK_MCLR   = 4'd4,
    BK_SSET   = 4'd6,
    BK_SCLR   = 4'd7,
    BK_PSET   = 4'd9,
    BK_PCLR   = 4'd10,
    BK_CTRL   = 4'd12
  } bank_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_EONLY = 1;
  localparam int CTL_FLUSH = 2;
endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_async;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irqr_detect.sv
module irqr_detect #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_sync,
  input  logic [NUM_LINES-1:0] sens,
  input  logic [NUM_LINES-1:0] pol,
  input  logic                 edge_only,
  output logic [NUM_LINES-1:0] evt
);
  logic [NUM_LINES-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= line_sync;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = line_sync[i] & ~prev[i];
    assign fall     = ~line_sync[i] & prev[i];
    assign edge_hit = pol[i] ? rise : fall;
    assign lvl_hit  = (line_sync[i] == pol[i]) & ~edge_only;
    assign evt[i]   = sens[i] ? lvl_hit : edge_hit;
  end
endmodule

// File: rtl/irqr_regfile.sv
module irqr_regfile
  import irqr_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [NUM_LINES-1:0] status,
  output logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] sens,
  output logic [NUM_LINES-1:0] pol,
  output logic [NUM_LINES-1:0] ack,
  output logic                 en,
  output logic                 edge_only,
  output logic                 flush_q
);
  localparam int WORDS = NUM_LINES / WORD_BITS;

  bank_e             bank;
  logic [WSEL_W-1:0] wsel;
  logic [1:0]        unused_lsb;

  assign bank       = bank_e'(addr[ADDR_W-1:BANK_LSB]);
  assign wsel       = addr[BANK_LSB-1:2];
  assign unused_lsb = addr[1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wsel == WSEL_W'(w));
    assign ack[w*WORD_BITS +: WORD_BITS] = (hit && bank == BK_ACK) ? wr_data : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        mask[w*WORD_BITS +: WORD_BITS] <= '1;
        sens[w*WORD_BITS +: WORD_BITS] <= '0;
        pol[w*WORD_BITS +: WORD_BITS]  <= '0;
      end else if (hit) begin
        case (bank)
          BK_MSET: mask[w*WORD_BITS +: WORD_BITS] <= mask[w*WORD_BITS +: WORD_BITS] | wr_data;
          BK_MCLR: mask[w*WORD_BITS +: WORD_BITS] <= mask[w*WORD_BITS +: WORD_BITS] & ~wr_data;
          BK_SSET: sens[w*WORD_BITS +: WORD_BITS] <= sens[w*WORD_BITS +: WORD_BITS] | wr_data;
          BK_SCLR: sens[w*WORD_BITS +: WORD_BITS] <= sens[w*WORD_BITS +: WORD_BITS] & ~wr_data;
          BK_PSET: pol[w*WORD_BITS +: WORD_BITS]  <= pol[w*WORD_BITS +: WORD_BITS] | wr_data;
          BK_PCLR: pol[w*WORD_BITS +: WORD_BITS]  <= pol[w*WORD_BITS +: WORD_BITS] & ~wr_data;
          default: ;
        endcase
      end
    end
  end

  logic ctrl_hit;
  assign ctrl_hit = wr_en && bank == BK_CTRL && wsel == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      edge_only <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      flush_q <= ctrl_hit && wr_data[CTL_FLUSH];
      if (ctrl_hit) begin
        en        <= wr_data[CTL_EN];
        edge_only <= wr_data[CTL_EONLY];
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    logic [31:0] st_w, mk_w, sn_w, pl_w;
    st_w = '0; mk_w = '0; sn_w = '0; pl_w = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (wsel == WSEL_W'(w)) begin
        st_w = status[w*WORD_BITS +: WORD_BITS];
        mk_w = mask[w*WORD_BITS +: WORD_BITS];
        sn_w = sens[w*WORD_BITS +: WORD_BITS];
        pl_w = pol[w*WORD_BITS +: WORD_BITS];
      end
    end
    case (bank)
      BK_STATUS:        rd_mux = st_w;
      BK_MSET, BK_MCLR: rd_mux = mk_w;
      BK_SSET, BK_SCLR: rd_mux = sn_w;
      BK_PSET, BK_PCLR: rd_mux = pl_w;
      BK_CTRL:          rd_mux = (wsel == '0) ? {30'd0, edge_only, en} : '0;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irqr_status.sv
module irqr_status #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] evt,
  input  logic [NUM_LINES-1:0] ack,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] line_sync,
  input  logic                 flush_q,
  input  logic                 en,
  output logic [NUM_LINES-1:0] status,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] replay;

  assign replay = flush_q ? (status & ~mask) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      irq_out <= '0;
    end else begin
      status  <= (status & ~ack & ~replay) | evt;
      irq_out <= replay | (en ? '0 : line_sync);
    end
  end
endmodule

// File: rtl/irq_hold_replay.sv
module irq_hold_replay
  import irqr_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] line_out
);
  logic [NUM_LINES-1:0] line_sync, evt, status, mask, sens, pol, ack;
  logic                 ctrl_en, ctrl_eonly, flush_q;

  irqr_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_async(line_in), .q_sync(line_sync)
  );

  irqr_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk(clk), .rst(rst), .line_sync(line_sync), .sens(sens), .pol(pol),
    .edge_only(ctrl_eonly), .evt(evt)
  );

  irqr_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .status(status), .mask(mask),
    .sens(sens), .pol(pol), .ack(ack), .en(ctrl_en), .edge_only(ctrl_eonly),
    .flush_q(flush_q)
  );

  irqr_status #(.NUM_LINES(NUM_LINES)) u_status (
    .clk(clk), .rst(rst), .evt(evt), .ack(ack), .mask(mask),
    .line_sync(line_sync), .flush_q(flush_q), .en(ctrl_en),
    .status(status), .irq_out(line_out)
  );
endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 flush_q,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] status,
  input logic [NUM_LINES-1:0] evt,
  input logic [NUM_LINES-1:0] line_out,
  input logic                 rd_en,
  input logic [9:0]           addr,
  input logic [31:0]          rd_data
);
  AST_ENABLED_ONLY_REPLAY: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> (line_out == '0 || $past(flush_q))); // R9

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> ((line_out & $past(mask)) == '0)); // R7

  AST_REPLAY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush_q |=> ((status & $past(status & ~mask) & ~$past(evt)) == '0)); // R7

  AST_STATUS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    ((status & ~$past(status) & ~$past(evt)) == '0)); // R4

  AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr[9:6] == 4'd12) |-> (rd_data[2] == 1'b0)); // R8
endmodule

bind irq_hold_replay irqr_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .en(ctrl_en), .flush_q(flush_q), .mask(mask),
  .status(status), .evt(evt), .line_out(line_out), .rd_en(reg_rd),
  .addr(reg_addr), .rd_data(reg_rdata)
);

// File: tb/irq_hold_replay_bench.sv
module irq_hold_replay_bench;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  line_in = '0;
  logic [N-1:0]  line_out;

  always #10 clk = ~clk;  // 50 MHz

  irq_hold_replay #(.NUM_LINES(N)) u_irq_hold_replay (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in), .line_out(line_out)
  );

  typedef struct { string tag; logic [31:0] exp; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    it.tag = tag; it.exp = e;
    exp_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        item_t it;
        @(negedge clk);
        if (exp_q.size() == 0) check("monitor: unexpected read", 64'd1, 64'd0);
        else begin
          it = exp_q.pop_front();
          check(it.tag, {32'd0, reg_rdata}, {32'd0, it.exp});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] exp_v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R1 line_out after reset", line_out, '0);
    rd(10'h000, 32'h0, "R1 status word0");
    rd(10'h0C0, 32'hFFFF_FFFF, "R1 mask word0");
    rd(10'h0C4, 32'hFFFF_FFFF, "R1 mask word1");
    rd(10'h300, 32'h0, "R1 control");
    rd(10'h180, 32'h0, "R1 sensitivity word0");

    // unmask lines 0 and 33, check zero-bit writes change nothing
    wr(10'h100, 32'h1);
    wr(10'h104, 32'h2);
    wr(10'h0C0, 32'h0);
    rd(10'h0C0, 32'hFFFF_FFFE, "R3 mask-clear line0, zero set ignored");
    rd(10'h104, 32'hFFFF_FFFD, "R2 mask word1 via clear address");
    wr(10'h240, 32'h1);
    rd(10'h280, 32'h1, "R3 polarity set line0");

    // edge recording while disabled, output follows input
    line_in[0] = 1'b1;
    idle(4);
    check("R9 disabled output follows input", line_out, 64'h1);
    rd(10'h000, 32'h1, "R4 rising edge recorded while disabled");
    line_in[33] = 1'b1;
    idle(4);
    rd(10'h004, 32'h0, "R4 rising edge ignored with polarity 0");
    line_in[33] = 1'b0;
    idle(4);
    rd(10'h004, 32'h2, "R4 falling edge recorded on line 33");

    // acknowledge
    wr(10'h040, 32'h1);
    wr(10'h044, 32'h0);
    rd(10'h000, 32'h0, "R6 ack clears line0");
    rd(10'h004, 32'h2, "R6 zero ack bits keep line33");

    // level line 5, active high
    wr(10'h180, 32'h20);
    wr(10'h240, 32'h20);
    rd(10'h240, 32'h21, "R3 polarity set keeps other bits");
    line_in[5] = 1'b1;
    idle(4);
    wr(10'h040, 32'h20);
    rd(10'h000, 32'h20, "R6 level event wins over ack");
    wr(10'h300, 32'h3);
    wr(10'h040, 32'h20);
    idle(2);
    rd(10'h000, 32'h0, "R5 level line ignored in edge-only mode");
    rd(10'h300, 32'h3, "R8 control readback");
    idle(2);
    check("R9 enabled output quiet", line_out, '0);

    // build pending events: line0 rising, line63 falling (masked)
    line_in[63] = 1'b1;
    line_in[0]  = 1'b0;
    idle(4);
    line_in[63] = 1'b0;
    line_in[0]  = 1'b1;
    idle(4);
    rd(10'h000, 32'h1, "R2 status word0 before replay");
    rd(10'h004, 32'h8000_0002, "R2 status word1 line63 bit31");

    // replay
    wr(10'h300, 32'h7);
    @(negedge clk);
    check("R7 no pulse in first cycle after write", line_out, '0);
    @(negedge clk);
    exp_v = '0; exp_v[0] = 1'b1; exp_v[33] = 1'b1;
    check("R7 replay pulse on unmasked lines", line_out, exp_v);
    @(negedge clk);
    check("R7 pulse lasts one cycle", line_out, '0);
    rd(10'h300, 32'h3, "R8 replay bit reads 0");
    rd(10'h000, 32'h0, "R7 replayed line0 cleared");
    rd(10'h004, 32'h8000_0000, "R7 masked line63 keeps status");

    // disable again
    wr(10'h300, 32'h0);
    idle(2);
    check("R9 disabled output tracks inputs", line_out, line_in);
    wr(10'h1C0, 32'h20);
    rd(10'h1C0, 32'h0, "R3 sensitivity clear");

    idle(4);
    check("scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule